// File: doc/BRIEF.md
# Feed-Sequence Watchdog Timer

This block is a watchdog that guards against a stalled program. A 24-bit counter counts down from a programmed reload value. It steps once every four clock cycles, through a fixed internal prescaler. Software keeps the count from running out by feeding the block. A feed is accepted only as two register writes in direct succession: the key 0xAA, then the key 0x55. A broken or wrong key sequence is handled like a timeout.

Expiry and feed faults share one response, which a mode bit selects. In reset mode the block raises a reset request for the chip's reset generator. In interrupt mode it sets a timeout flag that drives an interrupt line. Software can turn the watchdog on but cannot turn it off. Only a hardware reset, or the watchdog's own fault event, clears the enable.

A reset-cause flag sits in the power-on domain, so it survives the system reset that the watchdog itself triggers. A debug-halt input freezes the countdown while a debugger holds the core.

Top module: `wdt_feedseq`

## Requirements
- R1: After reset: enable, mode and timeout flag read 0, reload and count read 0xFF, and the reset request and interrupt outputs are low. The control register at address 0 holds enable in bit 0, mode in bit 1 (1 = reset request, 0 = interrupt) and the timeout flag in bit 2. Address 1 is reload, address 2 is the feed key (a read returns the count), and address 3 bit 0 is the reset-cause flag.
- R2: While enabled and not halted, the count decreases by one every fourth clock cycle. While disabled it does not change.
- R3: A write of 0xAA to address 2, followed on the very next access by a write of 0x55 to address 2, loads the count from the reload register and restarts the prescaler.
- R4: A reload write below 0xFF is stored as 0xFF. Any other value is stored unchanged.
- R5: In reset mode, with the block enabled, the reset request rises 4·(reload+1) cycles after a valid feed. It then stays high until rst_n is applied.
- R6: In interrupt mode the same event sets the timeout flag and raises irq. Writing 1 to control bit 2 clears both.
- R7: While enabled, a fault event is raised by either of two things. One is any access other than the 0x55 feed write directly after the 0xAA write. The other is a feed write of any value but 0xAA when no sequence is open.
- R8: Writing 1 to the enable bit sets it, and writing 0 has no effect. The mode bit cannot change while enabled. A fault event or a reset clears the enable.
- R9: The reset-cause flag is set by a reset-mode fault event. It survives rst_n, and is cleared only by por_n or by writing 1 to address 3 bit 0.
- R10: While dbg_halt is high, the count and prescaler hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous active-low; clears all state |
| rst_n | input | 1 | System reset, synchronous active-low; clears all but the reset-cause flag |
| acc_en | input | 1 | Register access strobe, one access per cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Register address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for a read access, 0 otherwise |
| dbg_halt | input | 1 | Freezes the countdown while high |
| rst_req | output | 1 | Reset request to the chip reset generator |
| irq | output | 1 | Watchdog interrupt |

## Verification
The countdown is tried with several patterns:
- Reads at fixed distances after a feed tell a divide-by-four step apart from any other rate.
- A long debug halt tells a frozen counter apart from one that still runs.
- Full expiries with reload 0xFF, in each mode, check the exact 1024-cycle window and which output responds.

The feed logic is driven with three patterns: a correct pair, a read slipped between the two keys, and a lone wrong key. Each must either reload the count or raise the fault. Resets are applied between these phases: a system reset after a reset-mode event, then a power-on reset. The reset-cause flag must survive the first and be cleared by the second.

// File: rtl/wdt_pkg.sv
// Package: shared register addresses, control bit positions and feed-state type.
// Assumes a 2-bit register address space.
package wdt_pkg;
    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_FEED   = 2'd2,
        REG_STAT   = 2'd3
    } reg_addr_e;

    localparam int CTRL_EN   = 0;
    localparam int CTRL_MODE = 1;
    localparam int CTRL_TOF  = 2;

    typedef enum logic {
        FS_IDLE  = 1'b0,
        FS_ARMED = 1'b1
    } feed_state_e;
endpackage

// File: rtl/wdt_prescaler.sv
// Module: divides the clock into one-cycle tick pulses, one every DIV cycles of run.
// Assumes: clr restarts the division; the count holds while run is low.
module wdt_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] div_q;

    assign tick = run && (div_q == PW'(DIV - 1));

    // Purpose: advance the divider phase while running, wrapping at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= tick ? '0 : div_q + 1'b1;
        end
    end

    // R10: the divider phase holds while run is low.
    p_phase_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(div_q));
endmodule

// File: rtl/wdt_counter.sv
// Module: down counter with load; flags expiry when a tick finds it at zero.
// Assumes: load has priority over tick; the count parks at zero after expiry.
module wdt_counter #(
    parameter int W    = 24,
    parameter int INIT = 255
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         expire
);
    assign expire = tick && !load && (cnt == '0);

    // Purpose: reload on feed, else step down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= W'(INIT);
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R2: a tick without a load lowers the count by exactly one.
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
    // R10: with no tick and no load, the count holds.
    p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));
endmodule

// File: rtl/wdt_feed_fsm.sv
// Module: checks the two-key feed sequence and reports a good feed or a fault.
// Assumes: one register access per cycle; clr abandons an open sequence.
module wdt_feed_fsm
    import wdt_pkg::*;
#(
    parameter logic [7:0] KEY_FIRST  = 8'hAA,
    parameter logic [7:0] KEY_SECOND = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       acc_en,
    input  logic       acc_we,
    input  logic [1:0] acc_addr,
    input  logic [7:0] key,
    output logic       feed_ok,
    output logic       feed_err
);
    feed_state_e state_q, state_d;
    logic        feed_wr;

    assign feed_wr = acc_en && acc_we && (acc_addr == REG_FEED);

    // Purpose: decide the next sequence state and the good/fault outcome.
    always_comb begin
        state_d  = state_q;
        feed_ok  = 1'b0;
        feed_err = 1'b0;
        unique case (state_q)
            FS_IDLE: begin
                if (feed_wr) begin
                    if (key == KEY_FIRST) state_d = FS_ARMED;
                    else                  feed_err = 1'b1;
                end
            end
            FS_ARMED: begin
                if (acc_en) begin
                    state_d = FS_IDLE;
                    if (feed_wr && key == KEY_SECOND) feed_ok  = 1'b1;
                    else                              feed_err = 1'b1;
                end
            end
            default: state_d = FS_IDLE;
        endcase
    end

    // Purpose: hold the sequence state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) state_q <= FS_IDLE;
        else               state_q <= state_d;
    end

    // R3: a good feed is always directly preceded by a first-key write.
    p_ok_after_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        feed_ok |-> $past(acc_en && acc_we && acc_addr == REG_FEED && key == KEY_FIRST));
endmodule

// File: rtl/wdt_feedseq.sv
// Module: top of the watchdog. Holds the control, reload and reset-cause
// registers, and joins the prescaler, the countdown and the feed checker.
// Assumes: por_n resets everything; rst_n resets all but the reset-cause flag.
module wdt_feedseq
    import wdt_pkg::*;
#(
    parameter int         CNT_W      = 24,
    parameter int         PRE_DIV    = 4,
    parameter int         MIN_RELOAD = 255,
    parameter int         DATA_W     = 32,
    parameter logic [7:0] KEY_FIRST  = 8'hAA,
    parameter logic [7:0] KEY_SECOND = 8'h55
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [1:0]        acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              dbg_halt,
    output logic              rst_req,
    output logic              irq
);
    localparam logic [CNT_W-1:0] RELOAD_FLOOR = CNT_W'(MIN_RELOAD);

    logic             rst_all_n;
    logic             en_q, mode_q, tof_q, cause_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt;
    logic             tick, expire, feed_ok, feed_err, fault_evt;
    logic             wr_ctrl, wr_reload, wr_stat;

    assign rst_all_n = rst_n && por_n;
    assign wr_ctrl   = acc_en && acc_we && (acc_addr == REG_CTRL);
    assign wr_reload = acc_en && acc_we && (acc_addr == REG_RELOAD);
    assign wr_stat   = acc_en && acc_we && (acc_addr == REG_STAT);
    assign fault_evt = en_q && (expire || feed_err);

    wdt_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_all_n),
        .run   (en_q && !dbg_halt),
        .clr   (feed_ok),
        .tick  (tick)
    );

    wdt_counter #(.W(CNT_W), .INIT(MIN_RELOAD)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_all_n),
        .tick     (tick),
        .load     (feed_ok),
        .load_val (reload_q),
        .cnt      (cnt),
        .expire   (expire)
    );

    wdt_feed_fsm #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_feed (
        .clk      (clk),
        .rst_n    (rst_all_n),
        .clr      (fault_evt),
        .acc_en   (acc_en),
        .acc_we   (acc_we),
        .acc_addr (acc_addr),
        .key      (acc_wdata[7:0]),
        .feed_ok  (feed_ok),
        .feed_err (feed_err)
    );

    // Purpose: set-only enable, cleared by a fault event or reset.
    always_ff @(posedge clk) begin
        if (!rst_all_n)                     en_q <= 1'b0;
        else if (fault_evt)                 en_q <= 1'b0;
        else if (wr_ctrl && acc_wdata[CTRL_EN]) en_q <= 1'b1;
    end

    // Purpose: response-mode bit, writable only while the watchdog is off.
    always_ff @(posedge clk) begin
        if (!rst_all_n)           mode_q <= 1'b0;
        else if (wr_ctrl && !en_q) mode_q <= acc_wdata[CTRL_MODE];
    end

    // Purpose: timeout flag, set by a fault event, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_all_n)                          tof_q <= 1'b0;
        else if (fault_evt)                      tof_q <= 1'b1;
        else if (wr_ctrl && acc_wdata[CTRL_TOF]) tof_q <= 1'b0;
    end

    // Purpose: reset request, held until a system reset arrives.
    always_ff @(posedge clk) begin
        if (!rst_all_n)              rst_req <= 1'b0;
        else if (fault_evt && mode_q) rst_req <= 1'b1;
    end

    // Purpose: reload register with a lower floor.
    always_ff @(posedge clk) begin
        if (!rst_all_n) begin
            reload_q <= RELOAD_FLOOR;
        end else if (wr_reload) begin
            reload_q <= (acc_wdata[CNT_W-1:0] < RELOAD_FLOOR) ? RELOAD_FLOOR
                                                               : acc_wdata[CNT_W-1:0];
        end
    end

    // Purpose: reset-cause flag in the power-on domain only.
    always_ff @(posedge clk) begin
        if (!por_n)                       cause_q <= 1'b0;
        else if (fault_evt && mode_q)     cause_q <= 1'b1;
        else if (wr_stat && acc_wdata[0]) cause_q <= 1'b0;
    end

    assign irq = tof_q && !mode_q;

    // Purpose: read mux, driving zero outside read accesses.
    always_comb begin
        acc_rdata = '0;
        if (acc_en && !acc_we) begin
            unique case (reg_addr_e'(acc_addr))
                REG_CTRL:   acc_rdata = DATA_W'({tof_q, mode_q, en_q});
                REG_RELOAD: acc_rdata = DATA_W'(reload_q);
                REG_FEED:   acc_rdata = DATA_W'(cnt);
                REG_STAT:   acc_rdata = DATA_W'(cause_q);
                default:    acc_rdata = '0;
            endcase
        end
    end

    // R8: enable stays set unless a fault event occurs.
    p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_all_n)
        (en_q && !fault_evt) |=> en_q);
    // R8: mode cannot change while enabled.
    p_mode_lock_r8: assert property (@(posedge clk) disable iff (!rst_all_n)
        en_q |=> $stable(mode_q));
    // R5: the reset request holds until reset.
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_all_n)
        rst_req |=> rst_req);
    // R9: a raised reset request is accompanied by the reset-cause flag.
    p_cause_set_r9: assert property (@(posedge clk) disable iff (!rst_all_n)
        $rose(rst_req) |-> cause_q);
    // R4: the stored reload never falls below the floor.
    p_reload_floor_r4: assert property (@(posedge clk) disable iff (!rst_all_n)
        reload_q >= RELOAD_FLOOR);
    // R6: irq and the reset request are never raised together.
    p_one_response_r6: assert property (@(posedge clk) disable iff (!rst_all_n)
        !(irq && rst_req));
endmodule

// File: tb/sim_wdt_feedseq.sv
// Bench: scoreboard. The read driver queues expected values, and a monitor
// compares them at the falling edge. Output checks run at 2 ns past the rising edge.
module sim_wdt_feedseq;
    logic        clk = 1'b0;
    logic        por_n, rst_n, acc_en, acc_we, dbg_halt;
    logic [1:0]  acc_addr;
    logic [31:0] acc_wdata, acc_rdata;
    logic        rst_req, irq;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    wdt_feedseq u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .dbg_halt(dbg_halt), .rst_req(rst_req), .irq(irq)
    );

    // Monitor: pop the expected value for each read access and compare.
    always @(negedge clk) begin
        if (acc_en && !acc_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read with nothing expected, actual %h", acc_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (acc_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, acc_rdata, e);
                end
            end
        end
    end

    task automatic access(input logic we, input logic [1:0] a, input logic [31:0] d);
        acc_en = 1'b1; acc_we = we; acc_addr = a; acc_wdata = d;
        @(posedge clk); #2;
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        access(1'b1, a, d);
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        access(1'b0, a, 32'h0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input logic act, input logic e, input string t);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", t, act, e);
        end
    endtask

    task automatic feed();
        wr(2'd2, 32'hAA);
        wr(2'd2, 32'h55);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        por_n = 1'b0; rst_n = 1'b0; acc_en = 1'b0; acc_we = 1'b0;
        acc_addr = 2'd0; acc_wdata = 32'h0; dbg_halt = 1'b0;
        @(posedge clk); #2;
        idle(2);
        por_n = 1'b1; rst_n = 1'b1;
        idle(1);

        // R1: reset state
        rd(2'd0, 32'h0, "R1 ctrl");
        rd(2'd1, 32'hFF, "R1 reload");
        rd(2'd2, 32'hFF, "R1 count");
        rd(2'd3, 32'h0, "R1 cause");
        chk(rst_req, 1'b0, "R1 rst_req");
        chk(irq, 1'b0, "R1 irq");

        // R4: reload floor
        wr(2'd1, 32'h10);
        rd(2'd1, 32'hFF, "R4 floor");
        wr(2'd1, 32'h300);
        rd(2'd1, 32'h300, "R4 pass");

        // R2: disabled counter holds; R3: valid feed reloads
        idle(20);
        rd(2'd2, 32'hFF, "R2 disabled hold");
        feed();
        rd(2'd2, 32'h300, "R3 feed reload");

        // R2: one step per four cycles when enabled
        wr(2'd0, 32'h1);
        feed();
        idle(8);
        rd(2'd2, 32'h2FE, "R2 divide by four");

        // R10: debug halt freezes
        dbg_halt = 1'b1;
        idle(40);
        rd(2'd2, 32'h2FE, "R10 halt freeze");
        dbg_halt = 1'b0;

        // R8: enable cannot be cleared, mode locked
        wr(2'd0, 32'h0);
        rd(2'd0, 32'h1, "R8 enable sticky");
        wr(2'd0, 32'h3);
        rd(2'd0, 32'h1, "R8 mode locked");

        // R7: access between keys is a fault
        wr(2'd2, 32'hAA);
        rd(2'd3, 32'h0, "R7 interleaved read");
        chk(irq, 1'b1, "R7 fault irq");
        rd(2'd0, 32'h4, "R8 fault clears enable");
        wr(2'd0, 32'h4);
        chk(irq, 1'b0, "R6 w1c clears irq");

        // R6: timeout in interrupt mode
        wr(2'd1, 32'hFF);
        wr(2'd0, 32'h1);
        feed();
        idle(1023);
        chk(irq, 1'b0, "R6 before expiry");
        idle(1);
        chk(irq, 1'b1, "R6 at expiry");
        chk(rst_req, 1'b0, "R6 no reset request");
        rd(2'd0, 32'h4, "R6 flag set, enable cleared");
        wr(2'd0, 32'h4);

        // R7: wrong key with no open sequence
        wr(2'd0, 32'h1);
        wr(2'd2, 32'h55);
        chk(irq, 1'b1, "R7 lone wrong key");
        wr(2'd0, 32'h4);

        // R5: timeout in reset mode
        wr(2'd0, 32'h2);
        wr(2'd0, 32'h3);
        feed();
        idle(1023);
        chk(rst_req, 1'b0, "R5 before expiry");
        idle(1);
        chk(rst_req, 1'b1, "R5 at expiry");
        chk(irq, 1'b0, "R5 no irq");
        idle(5);
        chk(rst_req, 1'b1, "R5 held");

        // R9: cause flag survives system reset
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        chk(rst_req, 1'b0, "R5 cleared by reset");
        rd(2'd0, 32'h0, "R8 reset clears enable");
        rd(2'd3, 32'h1, "R9 survives rst_n");
        wr(2'd3, 32'h1);
        rd(2'd3, 32'h0, "R9 write one clears");

        // R9: por_n clears the flag
        wr(2'd0, 32'h2);
        wr(2'd0, 32'h3);
        wr(2'd2, 32'hAA);
        wr(2'd2, 32'h12);
        chk(rst_req, 1'b1, "R7 wrong second key");
        rd(2'd3, 32'h1, "R9 set by fault");
        por_n = 1'b0;
        idle(2);
        por_n = 1'b1;
        rd(2'd3, 32'h0, "R9 cleared by por_n");

        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule